// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the processor-facing register file of a four-channel DMA controller. Software reaches it through one 8-bit data port and a 4-bit port select. Each channel has a 16-bit base and current address, a 16-bit base and current count, a transfer mode, a mask bit and an 8-bit page byte. The transfer engine reads every channel's settings from flat output vectors. It writes back the current address and count as transfers advance, and it can reload the current values from the base values to restart a buffer.

A 16-bit value moves over the 8-bit port as two accesses, low byte first and high byte second. A single byte-pointer flip-flop steers the bytes. Any access to an address or count port toggles it, whether a read or a write. A write to a dedicated port clears it. The page byte supplies address bits 23:16 beside the 16-bit current address. No carry passes from the address into the page. The count that software writes is one less than the number of transfers wanted; the block stores it unchanged. Software masks a channel, programs it, and then unmasks it.

Top module: `dma_port_regs`

## Requirements
- R1: After reset, every mask bit is 1. Every mode, direction and auto-reload field is 0. Every address, count and page is 0, the byte pointer selects the low byte, and the read data is 0.
- R2: Port select values 0 to 7 address the word registers. Bits [2:1] give the channel and bit 0 picks address (0) or count (1). A write to an address port fills the low byte when the pointer is low and the high byte when it is high, and writes the same byte to both the base and the current address. Each access toggles the pointer.
- R3: A write to a count port works the same way on the base and current count, and the value is stored exactly as written.
- R4: A write of any value to port 0xA clears the byte pointer, so the next word-port access uses the low byte.
- R5: A read of a word port returns the current value's low or high byte, as the shared pointer selects. The byte appears on rd_data_o in the cycle after rd_en_i. A read of a page port returns the page byte and does not move the pointer.
- R6: A write to port 0x8 programs the channel in data bits [1:0]. It sets the direction to bit 2, the auto-reload enable to bit 3 and the mode to bits [5:4]: 0 demand, 1 single, 2 block, 3 cascade.
- R7: A write to port 0x9 sets the mask of the channel in data bits [1:0] to the value of data bit 2. The masks of the other channels do not change.
- R8: A write to port 0xB sets all mask bits, clears every mode field and clears the byte pointer. Addresses, counts and pages keep their values.
- R9: Ports 0xC to 0xF write the page byte of channel sel[1:0]. The engine address output of a channel is {page, current address}, and a wrap of the current address leaves the page unchanged.
- R10: engine_upd_i loads the current address and count of a channel from the engine. reload_i copies the base values into the current values instead, and it wins over engine_upd_i. Neither changes the base values.
- R11: A processor write to a channel's address or count register in the same cycle as an engine update wins for that register. The other register still takes the engine value.
- R12: A write to one channel leaves every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Port write strobe |
| rd_en_i | input | 1 | Port read strobe |
| sel_i | input | 4 | Port select |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, registered |
| reload_i | input | 4 | Per channel: copy base values to current values |
| engine_upd_i | input | 4 | Per channel: load the engine's current values |
| engine_addr_i | input | 64 | Engine current address, 16 bits per channel |
| engine_cnt_i | input | 64 | Engine current count, 16 bits per channel |
| ch_addr_o | output | 96 | {page, current address}, 24 bits per channel |
| ch_cnt_o | output | 64 | Current count, 16 bits per channel |
| ch_mode_o | output | 8 | Transfer mode, 2 bits per channel |
| ch_dir_o | output | 4 | Direction per channel |
| ch_auto_o | output | 4 | Auto-reload enable per channel |
| ch_mask_o | output | 4 | Mask per channel |

## Verification
Every register write, engine update and reload appears on the channel outputs after the clock edge that samples it. The bench therefore drives each stimulus on a falling edge and checks the outputs on the next falling edge. A read byte is captured at the edge that samples rd_en_i. The monitor notes at that edge that a read took place, then compares rd_data_o at the following falling edge with the item at the head of the expected queue. Back-to-back reads yield one result per cycle in request order, which matches the queue order.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = WORD_W + PAGE_W;
  localparam int SEL_W  = 4;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    XFER_DEMAND  = 2'b00,
    XFER_SINGLE  = 2'b01,
    XFER_BLOCK   = 2'b10,
    XFER_CASCADE = 2'b11
  } xfer_mode_e;

  localparam logic [SEL_W-1:0] SEL_MODE   = 4'h8;
  localparam logic [SEL_W-1:0] SEL_MASK   = 4'h9;
  localparam logic [SEL_W-1:0] SEL_CLRPTR = 4'hA;
  localparam logic [SEL_W-1:0] SEL_MRST   = 4'hB;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic clear_i,
  output logic hi_o
);
  logic hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= 1'b0;
    else if (clear_i) hi_q <= 1'b0;
    else if (step_i)  hi_q <= ~hi_q;
  end

  assign hi_o = hi_q;

  // R4
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !hi_o);

  // R2
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> (hi_o != $past(hi_o)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              we_addr_i,
  input  logic              we_cnt_i,
  input  logic              we_mode_i,
  input  logic              we_mask_i,
  input  logic              we_page_i,
  input  logic              mrst_i,
  input  logic              reload_i,
  input  logic              upd_i,
  input  logic [WORD_W-1:0] upd_addr_i,
  input  logic [WORD_W-1:0] upd_cnt_i,
  output logic [WORD_W-1:0] cur_addr_o,
  output logic [WORD_W-1:0] cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              dir_o,
  output logic              auto_o,
  output logic              mask_o
);
  logic [WORD_W-1:0] base_addr_q, base_cnt_q, cur_addr_q, cur_cnt_q;
  logic [PAGE_W-1:0] page_q;
  xfer_mode_e        mode_q;
  logic              dir_q, auto_q, mask_q;

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    if (hi) r[WORD_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
    end else if (we_addr_i) begin
      base_addr_q <= put_byte(base_addr_q, hi_i, wdata_i);
      cur_addr_q  <= put_byte(cur_addr_q, hi_i, wdata_i);
    end else if (reload_i) begin
      cur_addr_q  <= base_addr_q;
    end else if (upd_i) begin
      cur_addr_q  <= upd_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_cnt_q <= '0;
      cur_cnt_q  <= '0;
    end else if (we_cnt_i) begin
      base_cnt_q <= put_byte(base_cnt_q, hi_i, wdata_i);
      cur_cnt_q  <= put_byte(cur_cnt_q, hi_i, wdata_i);
    end else if (reload_i) begin
      cur_cnt_q  <= base_cnt_q;
    end else if (upd_i) begin
      cur_cnt_q  <= upd_cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= XFER_DEMAND;
      dir_q  <= 1'b0;
      auto_q <= 1'b0;
      mask_q <= 1'b1;
      page_q <= '0;
    end else begin
      if (mrst_i) begin
        mode_q <= XFER_DEMAND;
        dir_q  <= 1'b0;
        auto_q <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (we_mode_i) begin
          dir_q  <= wdata_i[2];
          auto_q <= wdata_i[3];
          mode_q <= xfer_mode_e'(wdata_i[5:4]);
        end
        if (we_mask_i) mask_q <= wdata_i[2];
      end
      if (we_page_i) page_q <= wdata_i;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign page_o     = page_q;
  assign mode_o     = mode_q;
  assign dir_o      = dir_q;
  assign auto_o     = auto_q;
  assign mask_o     = mask_q;

  // R10
  reload_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !we_addr_i) |=> (cur_addr_o == $past(base_addr_q)));

  // R10
  upd_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !reload_i && !we_cnt_i) |=> (cur_cnt_o == $past(upd_cnt_i)));

  // R11
  cpu_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_addr_i && !hi_i) |=> (cur_addr_o[BYTE_W-1:0] == $past(wdata_i)));

  // R8
  mrst_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (mask_o && mode_o == XFER_DEMAND));

  // R9
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_page_i |=> $stable(page_o));
endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
  import dma_port_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  input  logic [NUM_CH-1:0]        reload_i,
  input  logic [NUM_CH-1:0]        engine_upd_i,
  input  logic [NUM_CH*WORD_W-1:0] engine_addr_i,
  input  logic [NUM_CH*WORD_W-1:0] engine_cnt_i,
  output logic [NUM_CH*ADDR_W-1:0] ch_addr_o,
  output logic [NUM_CH*WORD_W-1:0] ch_cnt_o,
  output logic [NUM_CH*MODE_W-1:0] ch_mode_o,
  output logic [NUM_CH-1:0]        ch_dir_o,
  output logic [NUM_CH-1:0]        ch_auto_o,
  output logic [NUM_CH-1:0]        ch_mask_o
);
  logic            hi;
  logic            is_word, is_cnt, is_page, mrst, clr;
  logic [CH_W-1:0] word_ch, page_ch, data_ch;
  logic [BYTE_W-1:0] rd_byte, rd_data_q;

  logic [WORD_W-1:0] cur_addr [NUM_CH];
  logic [WORD_W-1:0] cur_cnt  [NUM_CH];
  logic [PAGE_W-1:0] page     [NUM_CH];

  assign is_word = !sel_i[SEL_W-1];
  assign is_cnt  = sel_i[0];
  assign is_page = (sel_i[SEL_W-1:SEL_W-2] == 2'b11);
  assign word_ch = sel_i[CH_W:1];
  assign page_ch = sel_i[CH_W-1:0];
  assign data_ch = wdata_i[CH_W-1:0];
  assign mrst    = wr_en_i && (sel_i == SEL_MRST);
  assign clr     = wr_en_i && ((sel_i == SEL_CLRPTR) || (sel_i == SEL_MRST));

  dma_byte_ptr u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  ((wr_en_i || rd_en_i) && is_word),
    .clear_i (clr),
    .hi_o    (hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic we_addr, we_cnt, we_mode, we_mask, we_page;
    assign we_addr = wr_en_i && is_word && !is_cnt && (word_ch == CH_W'(g));
    assign we_cnt  = wr_en_i && is_word &&  is_cnt && (word_ch == CH_W'(g));
    assign we_mode = wr_en_i && (sel_i == SEL_MODE) && (data_ch == CH_W'(g));
    assign we_mask = wr_en_i && (sel_i == SEL_MASK) && (data_ch == CH_W'(g));
    assign we_page = wr_en_i && is_page && (page_ch == CH_W'(g));

    dma_chan_regs u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hi_i       (hi),
      .wdata_i    (wdata_i),
      .we_addr_i  (we_addr),
      .we_cnt_i   (we_cnt),
      .we_mode_i  (we_mode),
      .we_mask_i  (we_mask),
      .we_page_i  (we_page),
      .mrst_i     (mrst),
      .reload_i   (reload_i[g]),
      .upd_i      (engine_upd_i[g]),
      .upd_addr_i (engine_addr_i[g*WORD_W +: WORD_W]),
      .upd_cnt_i  (engine_cnt_i[g*WORD_W +: WORD_W]),
      .cur_addr_o (cur_addr[g]),
      .cur_cnt_o  (cur_cnt[g]),
      .page_o     (page[g]),
      .mode_o     (ch_mode_o[g*MODE_W +: MODE_W]),
      .dir_o      (ch_dir_o[g]),
      .auto_o     (ch_auto_o[g]),
      .mask_o     (ch_mask_o[g])
    );

    assign ch_addr_o[g*ADDR_W +: ADDR_W] = {page[g], cur_addr[g]};
    assign ch_cnt_o[g*WORD_W +: WORD_W]  = cur_cnt[g];
  end

  always_comb begin
    logic [WORD_W-1:0] w;
    w = is_cnt ? cur_cnt[word_ch] : cur_addr[word_ch];
    if (is_word)      rd_byte = hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    else if (is_page) rd_byte = page[page_ch];
    else              rd_byte = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_byte;
  end

  assign rd_data_o = rd_data_q;

  // R5
  rd_low_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && sel_i == 4'h0 && !hi)
      |=> (rd_data_o == $past(ch_addr_o[BYTE_W-1:0])));

  // R8
  mrst_all_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst |=> (&ch_mask_o));
endmodule

// File: tb/dma_port_regs_tb_top.sv
module dma_port_regs_tb_top;
  import dma_port_pkg::*;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [SEL_W-1:0]  sel = '0;
  logic [BYTE_W-1:0] wdata = '0;
  logic [BYTE_W-1:0] rd_data;
  logic [NUM_CH-1:0] reload = '0, upd = '0;
  logic [NUM_CH*WORD_W-1:0] e_addr = '0, e_cnt = '0;
  logic [NUM_CH*ADDR_W-1:0] ch_addr;
  logic [NUM_CH*WORD_W-1:0] ch_cnt;
  logic [NUM_CH*MODE_W-1:0] ch_mode;
  logic [NUM_CH-1:0] ch_dir, ch_auto, ch_mask;

  int checks = 0;
  int errors = 0;
  logic [BYTE_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_i(sel), .wdata_i(wdata), .rd_data_o(rd_data),
    .reload_i(reload), .engine_upd_i(upd),
    .engine_addr_i(e_addr), .engine_cnt_i(e_cnt),
    .ch_addr_o(ch_addr), .ch_cnt_o(ch_cnt), .ch_mode_o(ch_mode),
    .ch_dir_o(ch_dir), .ch_auto_o(ch_auto), .ch_mask_o(ch_mask)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [SEL_W-1:0] s, logic [BYTE_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [SEL_W-1:0] s, logic [BYTE_W-1:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; sel = s;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: result due at the falling edge after the sampling edge
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: unexpected read data %0h expected none", rd_data);
      end else begin
        logic [BYTE_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'h0, rd_data}, {24'h0, e});
      end
    end
  end

  function automatic logic [ADDR_W-1:0] addr_of(int c);
    return ch_addr[c*ADDR_W +: ADDR_W];
  endfunction
  function automatic logic [WORD_W-1:0] cnt_of(int c);
    return ch_cnt[c*WORD_W +: WORD_W];
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2);
    @(negedge clk);
    // R1 reset state
    check("R1 mask", {28'h0, ch_mask}, 32'hF);
    check("R1 mode", {24'h0, ch_mode}, 32'h0);
    check("R1 addr ch2", {8'h0, addr_of(2)}, 32'h0);
    check("R1 rd_data", {24'h0, rd_data}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 address ch2, low then high
    wr(4'hA, 8'h00);
    wr(4'h4, 8'h56);
    wr(4'h4, 8'h34);
    @(negedge clk);
    check("R2 addr ch2", {8'h0, addr_of(2)}, 32'h3456);

    // R9 page
    wr(4'hE, 8'h12);
    @(negedge clk);
    check("R9 page ch2", {8'h0, addr_of(2)}, 32'h123456);

    // R3 count
    wr(4'h5, 8'hFF);
    wr(4'h5, 8'h01);
    @(negedge clk);
    check("R3 cnt ch2", {16'h0, cnt_of(2)}, 32'h01FF);

    // R5 reads low then high, page read
    rd(4'h4, 8'h56, "R5 addr lo");
    rd(4'h4, 8'h34, "R5 addr hi");
    rd(4'h5, 8'hFF, "R5 cnt lo");
    rd(4'h5, 8'h01, "R5 cnt hi");
    rd(4'hE, 8'h12, "R5 page read");

    // R4 clear pointer mid-word
    wr(4'h4, 8'hAA);
    wr(4'hA, 8'h5A);
    wr(4'h4, 8'hBB);
    wr(4'h4, 8'h34);
    @(negedge clk);
    check("R4 addr ch2", {8'h0, addr_of(2)}, 32'h1234BB);

    // R6 modes: ch1 block, dir 1, auto 1; ch3 cascade
    wr(4'h8, 8'h2D);
    wr(4'h8, 8'h33);
    @(negedge clk);
    check("R6 mode", {24'h0, ch_mode}, {24'h0, 8'b11_00_10_00});
    check("R6 dir", {28'h0, ch_dir}, 32'h2);
    check("R6 auto", {28'h0, ch_auto}, 32'h2);

    // R7 masks
    wr(4'h9, 8'h02);
    wr(4'h9, 8'h00);
    @(negedge clk);
    check("R7 mask clr", {28'h0, ch_mask}, 32'hA);
    wr(4'h9, 8'h04);
    @(negedge clk);
    check("R7 mask set", {28'h0, ch_mask}, 32'hB);

    // R9 wrap without carry, R10 engine update
    @(negedge clk);
    upd = 4'b0100; e_addr[2*WORD_W +: WORD_W] = 16'hFFFF; e_cnt[2*WORD_W +: WORD_W] = 16'h0000;
    @(negedge clk);
    check("R10 upd addr", {8'h0, addr_of(2)}, 32'h12FFFF);
    check("R10 upd cnt", {16'h0, cnt_of(2)}, 32'h0);
    e_addr[2*WORD_W +: WORD_W] = 16'h0000;
    @(negedge clk);
    upd = '0;
    check("R9 no carry", {8'h0, addr_of(2)}, 32'h120000);

    // R10 reload beats update
    reload = 4'b0100; upd = 4'b0100; e_addr[2*WORD_W +: WORD_W] = 16'hDEAD;
    @(negedge clk);
    reload = '0; upd = '0;
    check("R10 reload addr", {8'h0, addr_of(2)}, 32'h1234BB);
    check("R10 reload cnt", {16'h0, cnt_of(2)}, 32'h01FF);

    // R5 read returns current value after update
    upd = 4'b0100; e_addr[2*WORD_W +: WORD_W] = 16'h7788;
    @(negedge clk);
    upd = '0;
    rd(4'h4, 8'h88, "R5 cur lo");
    rd(4'h4, 8'h77, "R5 cur hi");

    // R11 processor write wins on addr; count still updated
    @(negedge clk);
    wr_en = 1'b1; sel = 4'h4; wdata = 8'h11;
    upd = 4'b0100; e_addr[2*WORD_W +: WORD_W] = 16'h9999; e_cnt[2*WORD_W +: WORD_W] = 16'h4444;
    @(negedge clk);
    wr_en = 1'b0; upd = '0;
    check("R11 addr", {8'h0, addr_of(2)}, 32'h127711);
    check("R11 cnt", {16'h0, cnt_of(2)}, 32'h4444);

    // R8 master reset (pointer was high)
    wr(4'hB, 8'h00);
    @(negedge clk);
    check("R8 mask", {28'h0, ch_mask}, 32'hF);
    check("R8 mode", {24'h0, ch_mode}, 32'h0);
    check("R8 addr kept", {8'h0, addr_of(2)}, 32'h127711);
    rd(4'h4, 8'h11, "R8 ptr low");

    // R12 other channels untouched
    check("R12 ch0 addr", {8'h0, addr_of(0)}, 32'h0);
    check("R12 ch3 cnt", {16'h0, cnt_of(3)}, 32'h0);

    repeat (3) @(negedge clk);
    check("R5 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule